// File: doc/BRIEF.md
# Per-Channel Integral Nulling Controller

This block closes an integral feedback loop for up to 64 readout channels using one set of arithmetic. Decimated complex error samples come in as a tagged stream. Each sample carries a channel index and an in-phase and a quadrature component. For every sample the block multiplies each component by a shared programmable gain. It shifts the product right and adds the result into that channel's accumulator. The updated pair is then streamed out, tagged with the same channel. A waveform synthesizer uses this output as the channel's nulling amplitude while the loop for that channel is closed.

Accumulator state sits in a single memory that can be built from block RAM. The memory has one entry per channel, holding both lanes. It is read in the cycle a sample arrives and written back one cycle later. A one-entry forwarding register covers back-to-back samples on the same channel. A register-style configuration port sets one channel per write. The write opens or closes that channel's loop, and it can also zero the channel's accumulators.

Top module: `nuller_integrator`

## Requirements
- R1: Each of the 64 channels keeps its own I and Q accumulators. A sample tagged with channel k changes only channel k's values.
- R2: Every accepted input sample produces exactly one output. The output appears with `out_valid` high two clock cycles after the input cycle, and `out_ch` equals the input tag. When `out_valid` is low, `out_ch`, `out_i` and `out_q` keep their previous values.
- R3: When a channel's loop is closed, each lane is updated as acc + floor(sample * gain / 2^8). The sample is a signed 16-bit value, the gain is an unsigned 12-bit value, and I and Q are computed independently. The output carries the updated values.
- R4: Accumulators are signed 24-bit values. They saturate at 8388607 and -8388608 instead of wrapping.
- R5: A sample for a channel whose loop is open leaves that channel's accumulators unchanged. The output carries the unchanged values.
- R6: A configuration write with `cfg_clear` high zeroes both accumulators of `cfg_ch`. The loop state of that channel is set from `cfg_enable` in the same write.
- R7: If a configuration write and a sample target the same channel in the same cycle, the write wins. The sample is discarded, and its output carries the channel's values after the write.
- R8: After reset, every accumulator reads as zero, every loop is open and `out_valid` is low.
- R9: Samples on the same channel in consecutive cycles, or one cycle apart, each accumulate on top of the previous update. No update is lost.
- R10: The gain applied to a sample is the value present on `gain` in that sample's input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Error sample present this cycle |
| in_ch | input | 6 | Channel tag of the sample |
| in_i | input | 16 | Signed in-phase error |
| in_q | input | 16 | Signed quadrature error |
| gain | input | 12 | Unsigned loop gain, with 8 fractional bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 6 | Channel addressed by the write |
| cfg_enable | input | 1 | 1 closes the channel's loop, 0 opens it |
| cfg_clear | input | 1 | 1 zeroes the channel's accumulators |
| out_valid | output | 1 | Updated amplitude present |
| out_ch | output | 6 | Channel of the updated amplitude |
| out_i | output | 24 | Signed in-phase nulling amplitude |
| out_q | output | 24 | Signed quadrature nulling amplitude |

## Verification
Each accepted sample's result is due exactly two cycles after its input cycle. A configuration write affects any sample driven in the same cycle or later. The bench drives each sample on a falling edge and updates its own model of that channel immediately. It then queues the expected channel and values together with the cycle number in which the output must appear. On every falling edge the bench compares `out_valid` and the outputs against the head of the queue and the current cycle count. An early, late, missing or extra result is therefore reported just like a wrong value.

// File: rtl/nulint_pkg.sv
package nulint_pkg;
  typedef enum logic {LANE_I = 1'b0, LANE_Q = 1'b1} lane_e;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic en;
    logic clr;
  } cfg_t;
endpackage

// File: rtl/nulint_acc_ram.sv
module nulint_acc_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; returns the old word on a same-address write.
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nulint_lane_mac.sv
module nulint_lane_mac #(
  parameter int IN_W   = 16,
  parameter int GAIN_W = 12,
  parameter int ACC_W  = 24,
  parameter int SHIFT  = 8
) (
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic signed [IN_W-1:0]   sample,
  input  logic        [GAIN_W-1:0] gain,
  input  logic                     apply,
  output logic signed [ACC_W-1:0]  acc_out
);
  localparam int PW = IN_W + GAIN_W + 1;
  localparam int SW = ((PW > ACC_W) ? PW : ACC_W) + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [SW-1:0] sum;

  always_comb begin
    prod   = sample * $signed({1'b0, gain});
    scaled = prod >>> SHIFT;
    sum    = SW'(acc_in) + SW'(scaled);
    if (!apply)          acc_out = acc_in;
    else if (sum > MAXV) acc_out = MAXV[ACC_W-1:0];
    else if (sum < MINV) acc_out = MINV[ACC_W-1:0];
    else                 acc_out = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/nulint_chan_state.sv
module nulint_chan_state
  import nulint_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  cfg_t              cfg,
  input  logic              use_valid,
  input  logic [CH_W-1:0]   use_ch,
  output logic [NUM_CH-1:0] loop_en,
  output logic [NUM_CH-1:0] clr_pend
);
  // A pending-clear flag makes the stored word read as zero until the
  // next write-back to that channel; reset sets all of them.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        loop_en[c]  <= 1'b0;
        clr_pend[c] <= 1'b1;
      end else begin
        if (use_valid && use_ch == CH_W'(c)) clr_pend[c] <= 1'b0;
        if (cfg_we && cfg_ch == CH_W'(c)) begin
          loop_en[c] <= cfg.en;
          if (cfg.clr) clr_pend[c] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nuller_integrator.sv
module nuller_integrator
  import nulint_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int IN_W   = 16,
  parameter int GAIN_W = 12,
  parameter int ACC_W  = 24,
  parameter int SHIFT  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CH_W-1:0]         in_ch,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  input  logic [GAIN_W-1:0]       gain,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic                    cfg_enable,
  input  logic                    cfg_clear,
  output logic                    out_valid,
  output logic [CH_W-1:0]         out_ch,
  output logic signed [ACC_W-1:0] out_i,
  output logic signed [ACC_W-1:0] out_q
);
  localparam int WORD_W = NUM_LANES * ACC_W;

  logic [NUM_CH-1:0] loop_en, clr_pend;
  cfg_t              cfg_word;

  logic                             s1_valid, s1_drop;
  logic [CH_W-1:0]                  s1_ch;
  logic [GAIN_W-1:0]                s1_gain;
  logic [NUM_LANES-1:0][IN_W-1:0]   s1_smp;
  logic                             s1_apply;

  logic              fwd_valid;
  logic [CH_W-1:0]   fwd_ch;
  logic [WORD_W-1:0] fwd_word;
  logic [WORD_W-1:0] rd_word, base_word, new_word;

  assign cfg_word = '{en: cfg_enable, clr: cfg_clear};

  nulint_chan_state #(.NUM_CH(NUM_CH)) u_state (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg       (cfg_word),
    .use_valid (s1_valid),
    .use_ch    (s1_ch),
    .loop_en   (loop_en),
    .clr_pend  (clr_pend)
  );

  // Stage 0 -> 1: capture the sample while its accumulator word is read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_drop  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_drop  <= in_valid && cfg_we && (cfg_ch == in_ch);
    end
  end

  always_ff @(posedge clk) begin
    s1_ch                  <= in_ch;
    s1_gain                <= gain;
    s1_smp[int'(LANE_I)]   <= in_i;
    s1_smp[int'(LANE_Q)]   <= in_q;
  end

  nulint_acc_ram #(.DEPTH(NUM_CH), .DW(WORD_W)) u_ram (
    .clk   (clk),
    .we    (s1_valid),
    .waddr (s1_ch),
    .wdata (new_word),
    .raddr (in_ch),
    .rdata (rd_word)
  );

  // Pending clear beats forwarding, which beats the RAM word.
  always_comb begin
    if (clr_pend[s1_ch])                      base_word = '0;
    else if (fwd_valid && (fwd_ch == s1_ch))  base_word = fwd_word;
    else                                      base_word = rd_word;
  end

  assign s1_apply = loop_en[s1_ch] && !s1_drop;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    nulint_lane_mac #(
      .IN_W   (IN_W),
      .GAIN_W (GAIN_W),
      .ACC_W  (ACC_W),
      .SHIFT  (SHIFT)
    ) u_mac (
      .acc_in  (base_word[l*ACC_W +: ACC_W]),
      .sample  (s1_smp[l]),
      .gain    (s1_gain),
      .apply   (s1_apply),
      .acc_out (new_word[l*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fwd_valid <= 1'b0;
    else     fwd_valid <= s1_valid;
    fwd_ch   <= s1_ch;
    fwd_word <= new_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_ch <= s1_ch;
        out_i  <= new_word[int'(LANE_I)*ACC_W +: ACC_W];
        out_q  <= new_word[int'(LANE_Q)*ACC_W +: ACC_W];
      end
    end
  end
endmodule

// File: rtl/nulint_checker.sv
module nulint_checker #(
  parameter int CH_W  = 6,
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [CH_W-1:0]  in_ch,
  input logic             cfg_we,
  input logic [CH_W-1:0]  cfg_ch,
  input logic             cfg_clear,
  input logic             out_valid,
  input logic [CH_W-1:0]  out_ch,
  input logic [ACC_W-1:0] out_i,
  input logic [ACC_W-1:0] out_q
);
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_tag_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_ch == $past(in_ch, 2)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q) && $stable(out_ch)));

  // R6 and R7: a clear that collides with a sample yields zero amplitudes.
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_we && cfg_clear && (in_ch == cfg_ch))
      |-> ##2 ((out_i == '0) && (out_q == '0)));
endmodule

bind nuller_integrator nulint_checker #(.CH_W(CH_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ch     (in_ch),
  .cfg_we    (cfg_we),
  .cfg_ch    (cfg_ch),
  .cfg_clear (cfg_clear),
  .out_valid (out_valid),
  .out_ch    (out_ch),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/nuller_integrator_tb_top.sv
`timescale 1ns/1ps
module nuller_integrator_tb_top;
  localparam int NCH = 64;
  localparam longint AMAX = 64'sd8388607;
  localparam longint AMIN = -64'sd8388608;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  in_ch = '0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [11:0] gain = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_ch = '0;
  logic        cfg_enable = 1'b0, cfg_clear = 1'b0;
  logic        out_valid;
  logic [5:0]  out_ch;
  logic signed [23:0] out_i, out_q;

  always #5 clk = ~clk;

  nuller_integrator dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
    .in_i(in_i), .in_q(in_q), .gain(gain), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
    .out_valid(out_valid), .out_ch(out_ch), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint m_i [NCH];
  longint m_q [NCH];
  bit     m_en[NCH];

  int     q_due[$];
  int     q_ch [$];
  longint q_i  [$];
  longint q_q  [$];
  string  q_req[$];

  function automatic longint upd(longint acc, longint s, longint g);
    longint r;
    r = acc + ((s * g) >>> 8);
    if (r > AMAX) r = AMAX;
    if (r < AMIN) r = AMIN;
    return r;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_i[c] = 0; m_q[c] = 0; m_en[c] = 1'b0;
    end
  endtask

  task automatic step(bit v, int ch, int si, int sq, int g,
                      bit we, int cch, bit cen, bit cclr, string req);
    @(negedge clk);
    in_valid = v; in_ch = ch[5:0]; in_i = si[15:0]; in_q = sq[15:0];
    gain = g[11:0];
    cfg_we = we; cfg_ch = cch[5:0]; cfg_enable = cen; cfg_clear = cclr;
    if (we) begin
      m_en[cch] = cen;
      if (cclr) begin m_i[cch] = 0; m_q[cch] = 0; end
    end
    if (v) begin
      if (!(we && cch == ch) && m_en[ch]) begin
        m_i[ch] = upd(m_i[ch], si, g);
        m_q[ch] = upd(m_q[ch], sq, g);
      end
      q_due.push_back(cyc + 2); q_ch.push_back(ch);
      q_i.push_back(m_i[ch]); q_q.push_back(m_q[ch]); q_req.push_back(req);
    end
  endtask

  task automatic sample(int ch, int si, int sq, int g, string req);
    step(1'b1, ch, si, sq, g, 1'b0, 0, 1'b0, 1'b0, req);
  endtask

  task automatic cfg(int cch, bit cen, bit cclr);
    step(1'b0, 0, 0, 0, 0, 1'b1, cch, cen, cclr, "R6");
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R2");
  endtask

  // Scoreboard: every output is matched to its due cycle and value.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_chk++;
        if (q_due.size() == 0) begin
          n_fail++;
          $display("FAIL R2: extra output ch=%0d i=%0d q=%0d, expected none",
                   out_ch, out_i, out_q);
        end else begin
          if (cyc != q_due[0] || int'(out_ch) != q_ch[0] ||
              longint'(out_i) != q_i[0] || longint'(out_q) != q_q[0]) begin
            n_fail++;
            $display("FAIL %s: cyc=%0d ch=%0d i=%0d q=%0d, expected cyc=%0d ch=%0d i=%0d q=%0d",
                     q_req[0], cyc, out_ch, out_i, out_q,
                     q_due[0], q_ch[0], q_i[0], q_q[0]);
          end
          void'(q_due.pop_front()); void'(q_ch.pop_front());
          void'(q_i.pop_front()); void'(q_q.pop_front()); void'(q_req.pop_front());
        end
      end else if (q_due.size() > 0 && q_due[0] < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL R2: missing output at cyc=%0d, expected ch=%0d due cyc=%0d",
                 cyc, q_ch[0], q_due[0]);
        void'(q_due.pop_front()); void'(q_ch.pop_front());
        void'(q_i.pop_front()); void'(q_q.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2: watchdog expired at cyc=%0d, expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    // R8: reset state of the outputs
    n_chk++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0 || out_ch !== '0) begin
      n_fail++;
      $display("FAIL R8: out_valid=%0b ch=%0d i=%0d q=%0d, expected 0 0 0 0",
               out_valid, out_ch, out_i, out_q);
    end
    rst = 1'b0;

    // R8: open loop after reset, zero accumulators
    sample(9, 1234, -77, 256, "R8");
    cfg(10, 1'b1, 1'b0);
    sample(10, 5, -6, 256, "R8");

    // R3: unit gain, then fractional gain with floor rounding
    cfg(3, 1'b1, 1'b0);
    sample(3, 100, -50, 256, "R3");
    sample(3, -3, 3, 1, "R3");
    idle(2);

    // R9: back-to-back and one-apart updates on the same channel
    sample(3, 100, 10, 256, "R9");
    sample(3, 200, 20, 256, "R9");
    sample(3, 300, 30, 512, "R9");
    cfg(4, 1'b1, 1'b0);
    sample(4, 7, 7, 256, "R9");
    sample(3, 11, 12, 256, "R9");
    sample(4, 8, 9, 256, "R9");
    sample(3, 13, 14, 256, "R9");
    idle(2);

    // R10: gain taken in the sample's own cycle
    cfg(30, 1'b1, 1'b0);
    sample(30, 1000, -1000, 256, "R10");
    step(1'b0, 0, 0, 0, 4095, 1'b0, 0, 1'b0, 1'b0, "R10");
    sample(30, 10, 10, 512, "R10");
    sample(30, 10, 10, 0, "R10");

    // R1: heavy traffic on channel 21 leaves channel 20 alone
    cfg(20, 1'b1, 1'b0);
    cfg(21, 1'b1, 1'b0);
    sample(20, 555, -444, 256, "R1");
    for (int k = 0; k < 10; k++) sample(21, 3000, -3000, 4095, "R1");
    sample(20, 0, 0, 4095, "R1");

    // R4: positive and negative saturation
    cfg(5, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) sample(5, 32767, -32768, 4095, "R4");
    sample(5, -32768, 32767, 4095, "R4");

    // R5: open loop holds the value
    cfg(5, 1'b0, 1'b0);
    sample(5, -32768, 32767, 4095, "R5");
    sample(5, 1, 1, 256, "R5");

    // R6 and R7: clear colliding with a sample, loop re-closed
    step(1'b1, 5, 999, 999, 256, 1'b1, 5, 1'b1, 1'b1, "R7");
    sample(5, 40, -40, 256, "R6");
    // R7: non-clear write opening the loop in the sample's cycle
    step(1'b1, 3, 5000, 5000, 4095, 1'b1, 3, 1'b0, 1'b0, "R7");
    sample(3, 5000, 5000, 4095, "R5");
    // R6: clear between back-to-back samples
    cfg(4, 1'b1, 1'b0);
    sample(4, 100, 100, 256, "R6");
    step(1'b1, 4, 50, 50, 256, 1'b1, 4, 1'b1, 1'b1, "R6");
    sample(4, 60, 60, 256, "R6");
    idle(3);

    // R1: constrained random traffic mixed with configuration writes
    for (int k = 0; k < 4000; k++) begin
      bit v, we;
      int ch, cch;
      v   = ($urandom % 4) != 0;
      ch  = (($urandom % 5) == 0) ? int'($urandom % NCH) : int'($urandom % 8);
      we  = ($urandom % 10) == 0;
      cch = int'($urandom % 8);
      step(v, ch, int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($urandom % 4096), we, cch, ($urandom % 4) != 0,
           ($urandom % 3) == 0, "R1");
    end
    idle(5);

    n_chk++;
    if (q_due.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d outputs outstanding, expected 0", q_due.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule